// File: doc/BRIEF.md
# Double-Rate Command/Address Decoder with Power-Down Tracking

This block sits on the memory-device side of a 10-bit command/address bus that carries two halves of each command, one per clock edge. It captures the rising-edge half and the falling-edge half, joins them into a single command, and presents a decoded command code along with the bank, row, column, auto-precharge flag, mode-register address and mode-register data. It also tracks which banks hold an open row.

The block also follows the clock-enable input. When clock enable drops, the command sampled with that low value is not executed. Instead, together with the open-bank state, it selects one of four low-power states. Three of these states end when clock enable returns high, and the block then goes back to idle or active. The fourth, deep power-down, can only be left through reset.

A configuration input marks parts with four banks. For those parts the top bank bit is dropped and per-bank refresh is flagged as rejected.

Top module: `ddr_ca_decoder`

## Requirements
- R1: While `cs_n` is high at the rising edge, the command in that slot is a no-operation and `cmd_valid` stays low for it.
- R2: The rising-edge bits CA0, CA1 and CA2 (1 = H) select the command class. The output codes on `cmd_code` are:
  - HHH: no-operation, 0.
  - HL with CA2=H: read, 1. HL with CA2=L: write, 2.
  - LH: activate, 3.
  - LLH: refresh-all, 7, when CA3 is H; per-bank refresh, 8, when CA3 is L.
  - LLL: mode-register read, 9, when CA3 is H; mode-register write, 10, when CA3 is L.
- R3: When rising CA0..CA2 are HHL, CA3=L gives burst terminate (code 6). CA3=H gives precharge: precharge-all (code 5) if CA4=H, or one-bank precharge (code 4) with `bank` taken from rising CA9..CA7 if CA4=L.
- R4: For read and write, `bank` comes from rising CA9..CA7. Column bits come from rising CA5 (C1) and CA6 (C2), and from falling CA1..CA9 (C3..C11). `auto_pre` comes from falling CA0. `col[0]` is always 0.
- R5: For activate, `bank` comes from rising CA9..CA7. Row bits come from rising CA2..CA6 (R8..R12), falling CA0..CA7 (R0..R7) and falling CA8..CA9 (R13..R14).
- R6: For mode-register commands, `mr_addr` bits 0..5 come from rising CA4..CA9 and bits 6..7 from falling CA0..CA1. For writes, `mr_data` bits 0..7 come from falling CA2..CA9.
- R7: A command whose first half is sampled at rising edge N appears on the outputs just after rising edge N+1. `cmd_valid` is a one-cycle pulse.
- R8: If clock enable is low at a rising edge while the block is in state idle (0) or active (1), that slot's command is not executed. `pwr_state` moves at the next edge, chosen in this order:
  - self-refresh (4) for a refresh;
  - deep power-down (5) for a burst terminate;
  - active power-down (3) for anything else with a bank open;
  - idle power-down (2) otherwise.
- R9: In states 2, 3 and 4, every command is ignored (`cmd_valid` stays low). Clock enable high at a rising edge returns the block to active (1) if a bank is open, otherwise to idle (0). Open banks are kept across power-down.
- R10: State 5 is left only through reset. Clock enable high and any command leave it unchanged.
- R11: With `four_bank` high, the BA2 bit is forced to 0, both on the `bank` output and in open-bank tracking. A per-bank refresh reports code 11 (rejected) instead of 8.
- R12: After reset, `pwr_state` is idle (0), `cmd_valid` is low, and no bank is open.
- R13: Activate opens the addressed bank. One-bank precharge, or read/write with `auto_pre`, closes it. Precharge-all closes every bank. `pwr_state` shows active (1) while any bank is open and idle (0) otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge takes the first half, falling edge the second |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, sampled at the rising edge |
| cs_n | input | 1 | Active-low chip select, sampled at the rising edge |
| ca | input | CA_W | Shared command/address bus |
| four_bank | input | 1 | High for a device with four banks |
| cmd_valid | output | 1 | One-cycle pulse for an executed non-NOP command |
| cmd_code | output | 4 | Decoded command code (see R2, R3, R11) |
| bank | output | BANK_W | Bank address |
| row | output | ROW_W | Row address for activate |
| col | output | COL_W | Column address for read/write, bit 0 zero |
| auto_pre | output | 1 | Auto-precharge flag for read/write |
| mr_addr | output | 8 | Mode-register address |
| mr_data | output | 8 | Mode-register write data |
| pwr_state | output | 3 | 0 idle, 1 active, 2 idle PD, 3 active PD, 4 self-refresh, 5 deep PD |

## Verification
A wrong open-bank mask never shows up as a bad field. It shows up only in `pwr_state`: one cycle after an activate or precharge the state reads idle or active wrongly, and a power-down entry picks the wrong of states 2 and 3. A stuck or misrouted power state shows up one cycle after the clock-enable edge that should have moved it, either as a `cmd_valid` pulse that should have been blocked or as a missing one. Field-routing faults show up in the same cycle as the command's `cmd_valid` pulse, so each one is exposed by a single command with a distinctive bit pattern.

// File: rtl/ddrca_pkg.sv
package ddrca_pkg;

   typedef enum logic [3:0] {
      CMD_NOP      = 4'd0,
      CMD_READ     = 4'd1,
      CMD_WRITE    = 4'd2,
      CMD_ACT      = 4'd3,
      CMD_PRE_ONE  = 4'd4,
      CMD_PRE_ALL  = 4'd5,
      CMD_BST      = 4'd6,
      CMD_REF_ALL  = 4'd7,
      CMD_REF_BANK = 4'd8,
      CMD_MRR      = 4'd9,
      CMD_MRW      = 4'd10,
      CMD_REJECT   = 4'd11
   } cmd_e;

   typedef enum logic [2:0] {
      PWR_IDLE     = 3'd0,
      PWR_ACTIVE   = 3'd1,
      PWR_PD_IDLE  = 3'd2,
      PWR_PD_ACT   = 3'd3,
      PWR_SELF_REF = 3'd4,
      PWR_DEEP     = 3'd5
   } pwr_e;

endpackage

// File: rtl/ddrca_capture.sv
module ddrca_capture #(
   parameter int CA_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_n,
   input  logic            cke,
   input  logic [CA_W-1:0] ca,
   output logic [CA_W-1:0] rise_q,
   output logic [CA_W-1:0] fall_q,
   output logic            cs_q,
   output logic            cke_q
);

   // first half of the command, chip select and clock enable on the rising edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_q <= '1;
         cs_q   <= 1'b1;
         cke_q  <= 1'b1;
      end else begin
         rise_q <= ca;
         cs_q   <= cs_n;
         cke_q  <= cke;
      end
   end

   // second half on the falling edge of the same cycle
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) fall_q <= '0;
      else        fall_q <= ca;
   end

endmodule

// File: rtl/ddrca_decode.sv
module ddrca_decode
   import ddrca_pkg::*;
#(
   parameter int CA_W   = 10,
   parameter int BANK_W = 3,
   parameter int ROW_W  = 15,
   parameter int COL_W  = 12,
   parameter int MR_W   = 8
) (
   input  logic              cs_n,
   input  logic              four_bank,
   input  logic [CA_W-1:0]   rise,
   input  logic [CA_W-1:0]   fall,
   output cmd_e              cmd,
   output logic [BANK_W-1:0] bank,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col,
   output logic              ap,
   output logic [MR_W-1:0]   mr_addr,
   output logic [MR_W-1:0]   mr_data
);

   logic ras, cas, we;
   assign ras = rise[0];
   assign cas = rise[1];
   assign we  = rise[2];

   always_comb begin
      cmd = CMD_NOP;
      if (!cs_n) begin
         casez ({ras, cas, we})
            3'b111:  cmd = CMD_NOP;
            3'b110:  cmd = rise[3] ? (rise[4] ? CMD_PRE_ALL : CMD_PRE_ONE) : CMD_BST;
            3'b101:  cmd = CMD_READ;
            3'b100:  cmd = CMD_WRITE;
            3'b01?:  cmd = CMD_ACT;
            3'b001:  cmd = rise[3] ? CMD_REF_ALL : (four_bank ? CMD_REJECT : CMD_REF_BANK);
            default: cmd = rise[3] ? CMD_MRR : CMD_MRW;
         endcase
      end
   end

   // bank field: the top bit is dropped on four-bank parts
   generate
      if (BANK_W == 3) begin : g_bank8
         assign bank = four_bank ? {1'b0, rise[8:7]} : rise[9:7];
      end else begin : g_bank4
         assign bank = rise[8:7];
      end
   endgenerate

   assign row     = {fall[9:8], rise[6:2], fall[7:0]};
   assign col     = {fall[9:1], rise[6:5], 1'b0};
   assign ap      = fall[0];
   assign mr_addr = {fall[1:0], rise[9:4]};
   assign mr_data = fall[9:2];

endmodule

// File: rtl/ddrca_pwr_fsm.sv
module ddrca_pwr_fsm
   import ddrca_pkg::*;
#(
   parameter int BANK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke_s,
   input  cmd_e              cmd,
   input  logic [BANK_W-1:0] bank,
   input  logic              ap,
   output logic              accept,
   output pwr_e              state
);

   localparam int NB = 1 << BANK_W;

   logic [NB-1:0] open_q, open_nx;
   pwr_e          state_nx;
   logic          normal;

   assign normal = (state == PWR_IDLE) || (state == PWR_ACTIVE);
   assign accept = normal && cke_s;

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bank
         logic hit, set_b, clr_b;
         assign hit   = (bank == BANK_W'(b));
         assign set_b = accept && (cmd == CMD_ACT) && hit;
         assign clr_b = accept && ((cmd == CMD_PRE_ALL) ||
                        (hit && (cmd == CMD_PRE_ONE)) ||
                        (hit && ap && ((cmd == CMD_READ) || (cmd == CMD_WRITE))));
         assign open_nx[b] = set_b | (open_q[b] & ~clr_b);
      end
   endgenerate

   always_comb begin
      state_nx = state;
      unique case (state)
         PWR_IDLE, PWR_ACTIVE: begin
            if (!cke_s) begin
               if ((cmd == CMD_REF_ALL) || (cmd == CMD_REF_BANK) || (cmd == CMD_REJECT))
                  state_nx = PWR_SELF_REF;
               else if (cmd == CMD_BST)
                  state_nx = PWR_DEEP;
               else
                  state_nx = (|open_q) ? PWR_PD_ACT : PWR_PD_IDLE;
            end else begin
               state_nx = (|open_nx) ? PWR_ACTIVE : PWR_IDLE;
            end
         end
         PWR_PD_IDLE, PWR_PD_ACT, PWR_SELF_REF: begin
            if (cke_s) state_nx = (|open_q) ? PWR_ACTIVE : PWR_IDLE;
         end
         default: state_nx = PWR_DEEP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= PWR_IDLE;
         open_q <= '0;
      end else begin
         state  <= state_nx;
         open_q <= open_nx;
      end
   end

   AST_DEEP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PWR_DEEP) |=> (state == PWR_DEEP));  // R10

   AST_PD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (((state == PWR_PD_IDLE) || (state == PWR_PD_ACT) || (state == PWR_SELF_REF)) && cke_s)
      |=> ((state == PWR_IDLE) || (state == PWR_ACTIVE)));  // R9

endmodule

// File: rtl/ddr_ca_decoder.sv
module ddr_ca_decoder
   import ddrca_pkg::*;
#(
   parameter int CA_W   = 10,
   parameter int BANK_W = 3,
   parameter int ROW_W  = 15,
   parameter int COL_W  = 12,
   parameter int MR_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              cs_n,
   input  logic [CA_W-1:0]   ca,
   input  logic              four_bank,
   output logic              cmd_valid,
   output logic [3:0]        cmd_code,
   output logic [BANK_W-1:0] bank,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col,
   output logic              auto_pre,
   output logic [MR_W-1:0]   mr_addr,
   output logic [MR_W-1:0]   mr_data,
   output logic [2:0]        pwr_state
);

   generate
      if (CA_W != 10)                  begin : g_bad_ca   $error("CA_W must be 10");      end
      if (ROW_W != 15)                 begin : g_bad_row  $error("ROW_W must be 15");     end
      if (COL_W != 12)                 begin : g_bad_col  $error("COL_W must be 12");     end
      if (MR_W != 8)                   begin : g_bad_mr   $error("MR_W must be 8");       end
      if (BANK_W < 2 || BANK_W > 3)    begin : g_bad_bank $error("BANK_W must be 2..3");  end
   endgenerate

   logic [CA_W-1:0]   rise_q, fall_q;
   logic              cs_s, cke_s, accept, d_ap;
   cmd_e              d_cmd;
   pwr_e              st;
   logic [BANK_W-1:0] d_bank;
   logic [ROW_W-1:0]  d_row;
   logic [COL_W-1:0]  d_col;
   logic [MR_W-1:0]   d_mra, d_mrd;

   ddrca_capture #(.CA_W(CA_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cke(cke), .ca(ca),
      .rise_q(rise_q), .fall_q(fall_q), .cs_q(cs_s), .cke_q(cke_s)
   );

   ddrca_decode #(.CA_W(CA_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .MR_W(MR_W)) u_dec (
      .cs_n(cs_s), .four_bank(four_bank), .rise(rise_q), .fall(fall_q),
      .cmd(d_cmd), .bank(d_bank), .row(d_row), .col(d_col), .ap(d_ap),
      .mr_addr(d_mra), .mr_data(d_mrd)
   );

   ddrca_pwr_fsm #(.BANK_W(BANK_W)) u_pwr (
      .clk(clk), .rst_n(rst_n), .cke_s(cke_s), .cmd(d_cmd), .bank(d_bank),
      .ap(d_ap), .accept(accept), .state(st)
   );

   assign pwr_state = st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_code  <= CMD_NOP;
         bank      <= '0;
         row       <= '0;
         col       <= '0;
         auto_pre  <= 1'b0;
         mr_addr   <= '0;
         mr_data   <= '0;
      end else begin
         cmd_valid <= accept && (d_cmd != CMD_NOP);
         cmd_code  <= accept ? d_cmd : CMD_NOP;
         if (accept && (d_cmd != CMD_NOP)) begin
            bank     <= d_bank;
            row      <= d_row;
            col      <= d_col;
            auto_pre <= d_ap;
            mr_addr  <= d_mra;
            mr_data  <= d_mrd;
         end
      end
   end

   AST_CS_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !cmd_valid);  // R1

   AST_PD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((pwr_state == PWR_PD_IDLE) || (pwr_state == PWR_PD_ACT) ||
       (pwr_state == PWR_SELF_REF) || (pwr_state == PWR_DEEP)) |-> !cmd_valid);  // R9

   AST_FOUR_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (four_bank && $stable(four_bank) && cmd_valid) |->
      ((cmd_code != CMD_REF_BANK) && !bank[BANK_W-1]));  // R11

endmodule

// File: tb/sim_ddr_ca_decoder.sv
`timescale 1ns/1ps
module sim_ddr_ca_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke = 1'b1;
   logic        cs_n = 1'b1;
   logic [9:0]  ca = '1;
   logic        four_bank = 1'b0;
   logic        cmd_valid, auto_pre;
   logic [3:0]  cmd_code;
   logic [2:0]  bank, pwr_state;
   logic [14:0] row;
   logic [11:0] col;
   logic [7:0]  mr_addr, mr_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   ddr_ca_decoder u0 (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ca(ca), .four_bank(four_bank),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .bank(bank), .row(row), .col(col),
      .auto_pre(auto_pre), .mr_addr(mr_addr), .mr_data(mr_data), .pwr_state(pwr_state)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   // one command slot followed by one deselected slot; returns just after the result edge
   task automatic send(input logic cs, input logic [9:0] r, input logic [9:0] f, input logic k);
      @(negedge clk); #2;
      cs_n = cs; ca = r; cke = k;
      @(posedge clk); #2;
      ca = f;
      @(negedge clk); #2;
      cs_n = 1'b1; ca = '1;
      @(posedge clk); #2;
   endtask

   function automatic logic [9:0] r_rw(input logic [2:0] ba, input logic [11:0] c, input logic rd);
      return {ba, c[2], c[1], 2'b00, rd, 1'b0, 1'b1};
   endfunction
   function automatic logic [9:0] f_rw(input logic [11:0] c, input logic a);
      return {c[11:3], a};
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; cs_n = 1'b1; cke = 1'b1; ca = '1;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #2;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R12 state after reset", pwr_state, 0);
      chk("R12 valid after reset", cmd_valid, 0);
   endtask

   task automatic t_cs_high();
      send(1'b1, r_rw(3'd2, 12'h124, 1'b1), f_rw(12'h124, 1'b0), 1'b1);
      chk("R1 deselected read gives no valid", cmd_valid, 0);
      chk("R1 deselected code NOP", cmd_code, 0);
   endtask

   task automatic t_read_write();
      send(1'b0, r_rw(3'd5, 12'hB5F, 1'b1), f_rw(12'hB5F, 1'b1), 1'b1);
      chk("R7 read valid next edge", cmd_valid, 1);
      chk("R2 read code", cmd_code, 1);
      chk("R4 read bank", bank, 5);
      chk("R4 read column C0 zero", col, 12'hB5E);
      chk("R4 read auto precharge", auto_pre, 1);
      @(posedge clk); #2;
      chk("R7 valid is one cycle", cmd_valid, 0);
      send(1'b0, r_rw(3'd2, 12'h4A2, 1'b0), f_rw(12'h4A2, 1'b0), 1'b1);
      chk("R2 write code", cmd_code, 2);
      chk("R4 write bank", bank, 2);
      chk("R4 write column", col, 12'h4A2);
      chk("R4 write no auto precharge", auto_pre, 0);
   endtask

   task automatic t_act_pre();
      logic [14:0] rw;
      rw = 15'h5A3C;
      send(1'b0, {3'd3, rw[12:8], 2'b10}, {rw[14:13], rw[7:0]}, 1'b1);
      chk("R2 activate code", cmd_code, 3);
      chk("R5 activate bank", bank, 3);
      chk("R5 activate row", row, 15'h5A3C);
      chk("R13 active after activate", pwr_state, 1);
      send(1'b0, {3'd6, 7'b0001011}, 10'h0, 1'b1);
      chk("R3 one-bank precharge code", cmd_code, 4);
      chk("R13 other bank precharge keeps active", pwr_state, 1);
      send(1'b0, {3'd3, 7'b0001011}, 10'h0, 1'b1);
      chk("R3 precharge bank", bank, 3);
      chk("R13 idle after precharge", pwr_state, 0);
      send(1'b0, {3'd1, 5'b0, 2'b10}, 10'h0, 1'b1);
      send(1'b0, r_rw(3'd1, 12'h010, 1'b1), f_rw(12'h010, 1'b1), 1'b1);
      chk("R13 auto precharge closes bank", pwr_state, 0);
      send(1'b0, 10'b0000011011, 10'h0, 1'b1);
      chk("R3 precharge all code", cmd_code, 5);
      send(1'b0, 10'b0000000011, 10'h0, 1'b1);
      chk("R3 burst terminate code", cmd_code, 6);
   endtask

   task automatic t_mode_regs();
      logic [7:0] ma, op;
      ma = 8'hC7; op = 8'h96;
      send(1'b0, {ma[5:0], 4'b1000}, {8'h00, ma[7:6]}, 1'b1);
      chk("R2 mode read code", cmd_code, 9);
      chk("R6 mode read address", mr_addr, 8'hC7);
      ma = 8'h3A;
      send(1'b0, {ma[5:0], 4'b0000}, {op, ma[7:6]}, 1'b1);
      chk("R2 mode write code", cmd_code, 10);
      chk("R6 mode write address", mr_addr, 8'h3A);
      chk("R6 mode write data", mr_data, 8'h96);
      send(1'b0, 10'b0000001100, 10'h0, 1'b1);
      chk("R2 refresh all code", cmd_code, 7);
      send(1'b0, 10'b0000000100, 10'h0, 1'b1);
      chk("R2 per-bank refresh code", cmd_code, 8);
   endtask

   task automatic t_power_down();
      send(1'b0, 10'h3FF, 10'h3FF, 1'b0);
      chk("R8 NOP entry gives idle power-down", pwr_state, 2);
      chk("R8 entry command not executed", cmd_valid, 0);
      send(1'b0, r_rw(3'd1, 12'h020, 1'b1), f_rw(12'h020, 1'b0), 1'b0);
      chk("R9 read ignored in power-down", cmd_valid, 0);
      chk("R9 stays in power-down", pwr_state, 2);
      send(1'b1, 10'h3FF, 10'h3FF, 1'b1);
      chk("R9 exit to idle", pwr_state, 0);
      send(1'b0, {3'd4, 5'h11, 2'b10}, 10'h055, 1'b1);
      chk("R13 active before power-down", pwr_state, 1);
      send(1'b0, 10'h3FF, 10'h3FF, 1'b0);
      chk("R8 open bank gives active power-down", pwr_state, 3);
      send(1'b1, 10'h3FF, 10'h3FF, 1'b1);
      chk("R9 exit back to active", pwr_state, 1);
      send(1'b0, 10'b0000011011, 10'h0, 1'b1);
      chk("R13 precharge all returns idle", pwr_state, 0);
      send(1'b0, 10'b0000001100, 10'h0, 1'b0);
      chk("R8 refresh entry gives self-refresh", pwr_state, 4);
      chk("R8 refresh at entry not executed", cmd_valid, 0);
      send(1'b1, 10'h3FF, 10'h3FF, 1'b1);
      chk("R9 self-refresh exit to idle", pwr_state, 0);
   endtask

   task automatic t_four_bank();
      four_bank = 1'b1;
      send(1'b0, {3'd5, 5'h02, 2'b10}, 10'h001, 1'b1);
      chk("R11 top bank bit dropped", bank, 1);
      send(1'b0, {3'd1, 7'b0001011}, 10'h0, 1'b1);
      chk("R11 tracking uses masked bank", pwr_state, 0);
      send(1'b0, 10'b0000000100, 10'h0, 1'b1);
      chk("R11 per-bank refresh rejected", cmd_code, 11);
      chk("R11 rejected command still reported", cmd_valid, 1);
      four_bank = 1'b0;
      send(1'b0, {3'd5, 5'h02, 2'b10}, 10'h001, 1'b1);
      chk("R11 eight-bank keeps BA2", bank, 5);
      send(1'b0, 10'b0000011011, 10'h0, 1'b1);
   endtask

   task automatic t_deep();
      send(1'b0, 10'b0000000011, 10'h0, 1'b0);
      chk("R8 burst terminate entry gives deep power-down", pwr_state, 5);
      send(1'b1, 10'h3FF, 10'h3FF, 1'b1);
      chk("R10 clock enable high does not leave deep", pwr_state, 5);
      send(1'b0, {3'd2, 5'h03, 2'b10}, 10'h0, 1'b1);
      chk("R10 commands ignored in deep", cmd_valid, 0);
      chk("R10 still deep", pwr_state, 5);
      do_reset();
      chk("R10 reset leaves deep", pwr_state, 0);
   endtask

   initial begin
      t_reset();
      t_cs_high();
      t_read_write();
      t_act_pre();
      t_mode_regs();
      t_power_down();
      t_four_bank();
      t_deep();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule